// File: doc/BRIEF.md
# UART Host Register Bank with Interrupt Identification

This block is the processor-facing side of a classic PC-style serial port. A host talks to it over an 8-bit data bus with a 3-bit offset, a read strobe and a write strobe. It holds the interrupt-enable, line-control, modem-control and scratch registers and the 16-bit baud divisor. It assembles line-status and modem-status bytes from live inputs and sticky error flags. It ranks the pending interrupt causes into one identification code, and it drives a single interrupt request.

The shift registers, FIFOs and baud generator sit outside. They feed the block with received-byte, flag and status inputs. They take back single-cycle strobes: load the transmit holding register, pop the receive buffer, load FIFO control, and modem status read. They also take the divisor, the frame configuration and the modem-control bits. When line-control bit 7 is set, offsets 0 and 1 reach the divisor bytes in place of the data and enable registers.

Top module: `uart_regbank`

## Requirements
- R1: After reset the enable (offset 1), line-control (offset 3) and modem-control (offset 4) registers read 0x00. With both transmitter-empty inputs high, line status (offset 5) reads 0x60.
- R2: Scratch (offset 7) and line control read back the full byte last written. Modem control reads back the low 5 bits, with bits 7:5 reading 0.
- R3: While line-control bit 7 is 1, a write to offset 0 sets divisor bits 7:0 and a write to offset 1 sets bits 15:8. Reads of those offsets return the divisor bytes.
- R4: The transmit-load strobe (write to offset 0) and the receive-pop strobe (read of offset 0) assert only while line-control bit 7 is 0.
- R5: Identification (offset 2) reads 0x01 when nothing is pending. Otherwise bit 0 is 0 and bits 3:0 read 0x6 for line status, 0x4 for received data, 0xC for character timeout, 0x2 for transmit holding empty, and 0x0 for modem status.
- R6: When several causes are pending, the code reported is the one highest in this order: line status, received data, timeout, transmit empty, modem status.
- R7: Identification bits 7:6 read 11 while the FIFO-enabled input is high, and 00 otherwise.
- R8: The transmit-empty cause arms when the holding-empty input rises, or when enable bit 1 is written from 0 to 1 while the holding register is empty. It is cleared by a read of offset 2 that reports it, or by a transmit-load write. Clearing wins over arming in the same cycle.
- R9: Line-status bits 1 (overrun), 2 (parity), 3 (framing) and 4 (break) are sticky. A read of offset 5 clears them. An event that arrives in the cycle of that read is kept.
- R10: The interrupt output is high exactly when a cause is pending and modem-control bit 3 is 1.
- R11: Enable bit 0 gates the received-data and timeout causes, bit 1 transmit empty, bit 2 line status, and bit 3 modem status. A cause whose enable bit is 0 is never reported.
- R12: A write to offset 2 pulses the FIFO-control strobe. A read of offset 6 pulses the modem-status-read strobe and returns the modem line states in bits 7:4 and their change flags in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Interrupt request |
| rx_byte | input | 8 | Byte at the head of the receive path |
| rx_avail | input | 1 | Received data available |
| rx_tmo | input | 1 | Character timeout |
| rx_ev_overrun | input | 1 | Overrun event pulse |
| rx_ev_parity | input | 1 | Parity error event pulse |
| rx_ev_framing | input | 1 | Framing error event pulse |
| rx_ev_break | input | 1 | Break event pulse |
| rx_fifo_bad | input | 1 | Error present in receive FIFO |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_all_empty | input | 1 | Transmitter fully idle |
| fifo_on | input | 1 | FIFOs enabled |
| mdm_delta | input | 4 | Modem line change flags |
| mdm_lines | input | 4 | Modem line states |
| tx_load | output | 1 | Load the write data into the transmit holding register |
| rx_pop | output | 1 | Consume the received byte |
| fctl_load | output | 1 | Load the write data into FIFO control |
| mstat_read | output | 1 | Modem status read |
| divisor | output | 16 | Baud divisor |
| frame_cfg | output | 7 | Line-control bits 6:0 |
| mdm_ctl | output | 5 | Modem-control bits, bit 3 gates the interrupt, bit 4 is loopback |

## Verification
A wrong priority decision or a stale transmit-empty flag shows up on the read data of offset 2 and on the interrupt pin. This happens in the same cycle as the read, or one cycle after the clearing access. Sticky line-status errors that are lost or wrongly kept show on the next read of offset 5. A corrupted register or an aliasing error shows on the divisor and configuration outputs in the cycle after the write, and on the strobes in the cycle of the access. A reference model checks every output in every cycle, so any divergence is caught in the cycle where it first becomes visible.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_IDENT = 3'd2;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_MCTL  = 3'd4;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_MSTAT = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  // low nibble of the identification byte
  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_TXEMPTY = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TMO     = 4'hC
  } intid_e;

  typedef struct packed {
    logic tx_load;
    logic rx_pop;
    logic div_lo_wr;
    logic div_hi_wr;
    logic ien_wr;
    logic fctl_wr;
    logic lctl_wr;
    logic mctl_wr;
    logic scr_wr;
    logic ident_rd;
    logic lstat_rd;
    logic mstat_rd;
  } strobe_t;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_regbank_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic          dlab,
  output strobe_t       stb
);

  always_comb begin
    stb = '0;
    if (wr) begin
      unique case (addr)
        OFS_DATA:  begin stb.tx_load = ~dlab; stb.div_lo_wr = dlab; end
        OFS_IEN:   begin stb.ien_wr  = ~dlab; stb.div_hi_wr = dlab; end
        OFS_IDENT: stb.fctl_wr = 1'b1;
        OFS_LCTL:  stb.lctl_wr = 1'b1;
        OFS_MCTL:  stb.mctl_wr = 1'b1;
        OFS_SCR:   stb.scr_wr  = 1'b1;
        default:   ;
      endcase
    end
    if (rd) begin
      unique case (addr)
        OFS_DATA:  stb.rx_pop   = ~dlab;
        OFS_IDENT: stb.ident_rd = 1'b1;
        OFS_LSTAT: stb.lstat_rd = 1'b1;
        OFS_MSTAT: stb.mstat_rd = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/uart_rb_lstat.sv
module uart_rb_lstat #(
  parameter int unsigned ERRS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [ERRS-1:0] ev,
  output logic [ERRS-1:0] sticky
);

  logic [ERRS-1:0] sticky_d;
  logic            sticky_en;

  always_comb begin
    sticky_en = clr | (|ev);
    sticky_d  = (clr ? '0 : sticky) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky <= '0;
    else if (sticky_en) sticky <= sticky_d;
  end

  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev == '0) |=> (sticky == '0));

  // R9
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> ((sticky & $past(sticky)) == $past(sticky)));

endmodule

// File: rtl/uart_rb_intid.sv
module uart_rb_intid
  import uart_regbank_pkg::*;
#(
  parameter int unsigned IEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien,
  input  logic             err_any,
  input  logic             rx_avail,
  input  logic             rx_tmo,
  input  logic             tx_empty,
  input  logic             modem_any,
  input  logic             ien_arm,
  input  logic             tx_load,
  input  logic             ident_rd,
  output intid_e           code,
  output logic             pending
);

  logic thre_pend, thre_pend_d;
  logic empty_prev;
  logic thre_set, thre_clr;

  always_comb begin
    if      (ien[2] && err_any)   code = ID_LINE;
    else if (ien[0] && rx_avail)  code = ID_RXDATA;
    else if (ien[0] && rx_tmo)    code = ID_TMO;
    else if (ien[1] && thre_pend) code = ID_TXEMPTY;
    else if (ien[3] && modem_any) code = ID_MODEM;
    else                          code = ID_NONE;
    pending = (code != ID_NONE);
  end

  always_comb begin
    thre_set    = (tx_empty & ~empty_prev) | (ien_arm & tx_empty);
    thre_clr    = tx_load | (ident_rd & (code == ID_TXEMPTY));
    thre_pend_d = thre_clr ? 1'b0 : (thre_set ? 1'b1 : thre_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_pend  <= 1'b0;
      empty_prev <= 1'b1;
    end else begin
      thre_pend  <= thre_pend_d;
      empty_prev <= tx_empty;
    end
  end

  // R8
  thre_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_rd && code == ID_TXEMPTY) |=> !thre_pend);

  // R8
  thre_load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !thre_pend);

  // R6
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[2] && err_any) |-> (code == ID_LINE));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 3,
  parameter int unsigned ERRS   = 4,
  parameter int unsigned IEN_W  = 4,
  parameter int unsigned MCTL_W = 5,
  parameter int unsigned MDM    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  input  logic [DW-1:0]     rx_byte,
  input  logic              rx_avail,
  input  logic              rx_tmo,
  input  logic              rx_ev_overrun,
  input  logic              rx_ev_parity,
  input  logic              rx_ev_framing,
  input  logic              rx_ev_break,
  input  logic              rx_fifo_bad,
  input  logic              tx_hold_empty,
  input  logic              tx_all_empty,
  input  logic              fifo_on,
  input  logic [MDM-1:0]    mdm_delta,
  input  logic [MDM-1:0]    mdm_lines,
  output logic              tx_load,
  output logic              rx_pop,
  output logic              fctl_load,
  output logic              mstat_read,
  output logic [2*DW-1:0]   divisor,
  output logic [DW-2:0]     frame_cfg,
  output logic [MCTL_W-1:0] mdm_ctl
);

  localparam int unsigned DLAB_BIT  = DW - 1;
  localparam int unsigned IRQ_GATE  = 3;
  localparam int unsigned ID_PAD    = DW - 6;

  // reset: asserted at once, released two edges later
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic [IEN_W-1:0]  ien_q;
  logic [DW-1:0]     lctl_q, scr_q, div_lo_q, div_hi_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [ERRS-1:0]   err_q;
  strobe_t           stb;
  intid_e            code;
  logic              pending;
  logic              dlab;

  assign dlab = lctl_q[DLAB_BIT];

  uart_rb_decode #(.AW(AW)) u_decode (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .dlab (dlab),
    .stb  (stb)
  );

  uart_rb_lstat #(.ERRS(ERRS)) u_lstat (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr    (stb.lstat_rd),
    .ev     ({rx_ev_break, rx_ev_framing, rx_ev_parity, rx_ev_overrun}),
    .sticky (err_q)
  );

  uart_rb_intid #(.IEN_W(IEN_W)) u_intid (
    .clk       (clk),
    .rst_n     (rst_s),
    .ien       (ien_q),
    .err_any   (|err_q),
    .rx_avail  (rx_avail),
    .rx_tmo    (rx_tmo),
    .tx_empty  (tx_hold_empty),
    .modem_any (|mdm_delta),
    .ien_arm   (stb.ien_wr & bus_wdata[1] & ~ien_q[1]),
    .tx_load   (stb.tx_load),
    .ident_rd  (stb.ident_rd),
    .code      (code),
    .pending   (pending)
  );

  // register next-state
  logic [IEN_W-1:0]  ien_d;
  logic [DW-1:0]     lctl_d, scr_d, div_lo_d, div_hi_d;
  logic [MCTL_W-1:0] mctl_d;

  always_comb begin
    ien_d    = bus_wdata[IEN_W-1:0];
    lctl_d   = bus_wdata;
    scr_d    = bus_wdata;
    div_lo_d = bus_wdata;
    div_hi_d = bus_wdata;
    mctl_d   = bus_wdata[MCTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ien_q    <= '0;
      lctl_q   <= '0;
      mctl_q   <= '0;
      scr_q    <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else begin
      if (stb.ien_wr)    ien_q    <= ien_d;
      if (stb.lctl_wr)   lctl_q   <= lctl_d;
      if (stb.mctl_wr)   mctl_q   <= mctl_d;
      if (stb.scr_wr)    scr_q    <= scr_d;
      if (stb.div_lo_wr) div_lo_q <= div_lo_d;
      if (stb.div_hi_wr) div_hi_q <= div_hi_d;
    end
  end

  // read multiplexer
  always_comb begin
    unique case (bus_addr)
      OFS_DATA:  bus_rdata = dlab ? div_lo_q : rx_byte;
      OFS_IEN:   bus_rdata = dlab ? div_hi_q : {{(DW-IEN_W){1'b0}}, ien_q};
      OFS_IDENT: bus_rdata = {{2{fifo_on}}, {ID_PAD{1'b0}}, code};
      OFS_LCTL:  bus_rdata = lctl_q;
      OFS_MCTL:  bus_rdata = {{(DW-MCTL_W){1'b0}}, mctl_q};
      OFS_LSTAT: bus_rdata = {rx_fifo_bad, tx_all_empty, tx_hold_empty, err_q, rx_avail};
      OFS_MSTAT: bus_rdata = {mdm_lines, mdm_delta};
      default:   bus_rdata = scr_q;
    endcase
  end

  assign irq        = pending & mctl_q[IRQ_GATE];
  assign tx_load    = stb.tx_load;
  assign rx_pop     = stb.rx_pop;
  assign fctl_load  = stb.fctl_wr;
  assign mstat_read = stb.mstat_rd;
  assign divisor    = {div_hi_q, div_lo_q};
  assign frame_cfg  = lctl_q[DW-2:0];
  assign mdm_ctl    = mctl_q;

  // R4
  load_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (tx_load || rx_pop) |-> !lctl_q[DLAB_BIT]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    irq |-> (mdm_ctl[IRQ_GATE] && code != ID_NONE));

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ien_q == '0) |-> !pending);

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(stb.div_lo_wr || stb.div_hi_wr) |=> $stable(divisor));

endmodule

// File: tb/uart_regbank_tb.sv
`timescale 1ns/1ps
module uart_regbank_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, rx_byte;
  logic       irq, rx_avail, rx_tmo, rx_ev_overrun, rx_ev_parity, rx_ev_framing, rx_ev_break;
  logic       rx_fifo_bad, tx_hold_empty, tx_all_empty, fifo_on;
  logic [3:0] mdm_delta, mdm_lines;
  logic       tx_load, rx_pop, fctl_load, mstat_read;
  logic [15:0] divisor;
  logic [6:0] frame_cfg;
  logic [4:0] mdm_ctl;

  uart_regbank u_dut (.*);

  int vectors = 0;
  int errors  = 0;

  // reference state
  bit [3:0] m_ien; bit [7:0] m_lcr, m_scr, m_dll, m_dlm; bit [4:0] m_mcr;
  bit [3:0] m_err; bit m_thre, m_prev;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ident_code();
    if (m_ien[2] && m_err != 0)         return 6;
    if (m_ien[0] && rx_avail)           return 4;
    if (m_ien[0] && rx_tmo)             return 12;
    if (m_ien[1] && m_thre)             return 2;
    if (m_ien[3] && mdm_delta != 0)     return 0;
    return 1;
  endfunction

  function automatic int exp_rdata();
    bit dl = m_lcr[7];
    case (bus_addr)
      0: return dl ? m_dll : rx_byte;
      1: return dl ? m_dlm : m_ien;
      2: return ident_code() | (fifo_on ? 8'hC0 : 0);
      3: return m_lcr;
      4: return m_mcr;
      5: return {rx_fifo_bad, tx_all_empty, tx_hold_empty, m_err, rx_avail};
      6: return {mdm_lines, mdm_delta};
      default: return m_scr;
    endcase
  endfunction

  // one clock: compare at the falling edge, then advance the model
  task automatic step(input string tag, input int exp_rd = -1, input int exp_irq = -1);
    int id; bit dl, txw, clr, set;
    @(negedge clk);
    dl = m_lcr[7];
    id = ident_code();
    chk({tag, " R5/R2 rdata"}, bus_rdata, exp_rdata());
    chk("R10 irq", irq, (id != 1) && m_mcr[3]);
    chk("R4 tx_load", tx_load, bus_wr && bus_addr == 0 && !dl);
    chk("R4 rx_pop", rx_pop, bus_rd && bus_addr == 0 && !dl);
    chk("R12 fctl_load", fctl_load, bus_wr && bus_addr == 2);
    chk("R12 mstat_read", mstat_read, bus_rd && bus_addr == 6);
    chk("R3 divisor", divisor, {m_dlm, m_dll});
    chk("R2 frame_cfg", frame_cfg, m_lcr[6:0]);
    chk("R2 mdm_ctl", mdm_ctl, m_mcr);
    if (exp_rd >= 0)  chk({tag, " directed rdata"}, bus_rdata, exp_rd);
    if (exp_irq >= 0) chk({tag, " directed irq"}, irq, exp_irq);
    txw = bus_wr && bus_addr == 0 && !dl;
    clr = txw || (bus_rd && bus_addr == 2 && id == 2);
    set = (tx_hold_empty && !m_prev) ||
          (bus_wr && bus_addr == 1 && !dl && bus_wdata[1] && !m_ien[1] && tx_hold_empty);
    m_thre = clr ? 1'b0 : (set ? 1'b1 : m_thre);
    m_prev = tx_hold_empty;
    m_err  = ((bus_rd && bus_addr == 5) ? 4'h0 : m_err) |
             {rx_ev_break, rx_ev_framing, rx_ev_parity, rx_ev_overrun};
    if (bus_wr) begin
      case (bus_addr)
        0: if (dl) m_dll = bus_wdata;
        1: if (dl) m_dlm = bus_wdata; else m_ien = bus_wdata[3:0];
        3: m_lcr = bus_wdata;
        4: m_mcr = bus_wdata[4:0];
        7: m_scr = bus_wdata;
        default: ;
      endcase
    end
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d, input string tag);
    bus_addr = a[2:0]; bus_wdata = d[7:0]; bus_wr = 1; step(tag); bus_wr = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    bus_addr = a[2:0]; bus_rd = 1; step(tag, exp); bus_rd = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; rx_byte = 8'h3C;
    rx_avail = 0; rx_tmo = 0; rx_ev_overrun = 0; rx_ev_parity = 0; rx_ev_framing = 0;
    rx_ev_break = 0; rx_fifo_bad = 0; tx_hold_empty = 1; tx_all_empty = 1; fifo_on = 0;
    mdm_delta = 0; mdm_lines = 0;
    m_ien = 0; m_lcr = 0; m_scr = 0; m_dll = 0; m_dlm = 0; m_mcr = 0; m_err = 0;
    m_thre = 0; m_prev = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset values
    rd(1, 8'h00, "R1 ien");
    rd(3, 8'h00, "R1 lctl");
    rd(4, 8'h00, "R1 mctl");
    rd(5, 8'h60, "R1 lstat");
    rd(2, 8'h01, "R5 idle");
    // R2 readback
    wr(7, 8'hA5, "R2"); rd(7, 8'hA5, "R2 scratch");
    wr(3, 8'h1B, "R2"); rd(3, 8'h1B, "R2 lctl");
    wr(4, 8'hFF, "R2"); rd(4, 8'h1F, "R2 mctl");
    // R3 / R4 divisor aliasing
    wr(3, 8'h83, "R3");
    wr(0, 8'h34, "R3 lo"); wr(1, 8'h12, "R3 hi");
    chk("R3 divisor value", divisor, 16'h1234);
    rd(0, 8'h34, "R3 alias lo"); rd(1, 8'h12, "R3 alias hi");
    wr(3, 8'h03, "R3");
    rd(0, 8'h3C, "R4 data path");
    // R8 transmit empty
    wr(1, 8'h02, "R8 arm");
    bus_addr = 2; bus_rd = 1; step("R8 report", 8'h02, 1); bus_rd = 0;
    rd(2, 8'h01, "R8 read clears");
    wr(1, 8'h00, "R8"); wr(1, 8'h02, "R8 rearm");
    wr(0, 8'h55, "R8 load");
    rd(2, 8'h01, "R8 load clears");
    // R6 priority
    wr(1, 8'h0F, "R6");
    rx_ev_overrun = 1; rx_avail = 1; mdm_delta = 4'h1; step("R6"); rx_ev_overrun = 0;
    rd(2, 8'h06, "R6 line first");
    rd(5, 8'h63, "R9 overrun seen");
    rd(2, 8'h04, "R6 data next");
    rx_avail = 0; rx_tmo = 1;
    rd(2, 8'h0C, "R6 timeout next");
    rx_tmo = 0;
    rd(2, 8'h00, "R6 modem last");
    fifo_on = 1;
    rd(2, 8'hC0, "R7 fifo bits");
    mdm_delta = 0;
    rd(2, 8'hC1, "R7 idle with fifo");
    fifo_on = 0;
    // R9 event during clearing read
    bus_addr = 5; bus_rd = 1; rx_ev_parity = 1; step("R9 race", 8'h60);
    bus_rd = 0; rx_ev_parity = 0;
    rd(5, 8'h64, "R9 kept");
    rd(5, 8'h60, "R9 cleared");
    // R10 gate
    rx_avail = 1;
    wr(4, 8'h00, "R10");
    step("R10 gated", -1, 0);
    wr(4, 8'h08, "R10");
    step("R10 open", -1, 1);
    // R11 masking
    wr(1, 8'h00, "R11");
    rd(2, 8'h01, "R11 masked");
    rx_avail = 0;
    // R12
    wr(2, 8'hC7, "R12 fctl");
    mdm_lines = 4'hA; mdm_delta = 4'h5;
    rd(6, 8'hA5, "R12 mstat");
    mdm_delta = 0;
    // random traffic, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 4;
      bus_addr  = $urandom; bus_wdata = $urandom; rx_byte = $urandom;
      bus_rd = (op == 0); bus_wr = (op == 1);
      rx_avail = $urandom; rx_tmo = ($urandom % 4) == 0;
      rx_ev_overrun = ($urandom % 8) == 0; rx_ev_parity = ($urandom % 8) == 0;
      rx_ev_framing = ($urandom % 8) == 0; rx_ev_break = ($urandom % 8) == 0;
      rx_fifo_bad = $urandom; tx_hold_empty = $urandom; tx_all_empty = $urandom;
      fifo_on = $urandom; mdm_delta = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      mdm_lines = $urandom;
      step("random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule